// File: doc/BRIEF.md
# I2C Interrupt Vector Encoder

This block sits beside the byte engine of an I2C controller and turns its scattered event signals into a single interrupt source. Short event pulses (arbitration lost, NACK seen, register access ready, stop seen, addressed as a target) are latched into sticky flags. The receive-available and transmit-space conditions come straight from the data path as levels. Every flag is gated by an enable register. Among the pending enabled events, the one with the smallest code is presented as a 3-bit vector, and a level interrupt line follows the vector.

Software reaches the block over a simple register port with four addresses. Address 0 is the status register. Address 1 is the enable register. Address 2 is the vector register. Address 3 reads as zero. Software services the block in one of two ways: it reads the vector, which acknowledges the event it reports, or it writes ones into status to clear the flags that permit it.

Top module: `i2c_irq_vec`

## Requirements
- R1: After reset the enable register is 0, every sticky flag is 0, `irq_code` is 0 and `irq_line` is low.
- R2: A read of status (address 0) shows the flags at these bits: 0 arbitration lost, 1 NACK, 2 access ready, 3 receive available, 4 transmit space, 5 stop seen, 6 addressed. Bit 11 mirrors `rx_shift_full` and bit 12 mirrors `bus_busy`. All other bits read 0. An event pulse sets its sticky flag at the next clock edge.
- R3: A write to address 1 loads `bus_wdata[6:0]` into the enable register, using the same bit order as status. A read of address 1 returns the register in bits 6:0, with the upper bits at 0.
- R4: The vector codes are: 1 arbitration lost, 2 NACK, 3 access ready, 4 receive available, 5 transmit space, 6 stop seen, 7 addressed. When several enabled events are pending, the smallest code is reported. The vector appears on `irq_code` and in bits 2:0 of a read of address 2.
- R5: When no enabled event is pending, the vector is 0. A disabled event still sets its status flag.
- R6: `irq_line` is high exactly when `irq_code` is nonzero.
- R7: Writing 1 to status bit 2 or bit 5 clears that flag at the next edge. Writing ones to any other status bit has no effect.
- R8: A read of address 2 clears the sticky flag it reports at the next edge. Codes 4 and 5 are levels, and the read leaves them unchanged.
- R9: An event pulse in the same cycle as a clear of its flag wins, whether the clear comes from a status write or a vector read. The flag stays set.
- R10: A write to address 2 or 3 changes nothing, and a read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_nack | input | 1 | Pulse: NACK received |
| ev_acc_rdy | input | 1 | Pulse: register access ready |
| ev_stop_det | input | 1 | Pulse: stop condition seen |
| ev_slave_hit | input | 1 | Pulse: addressed as target |
| rx_avail | input | 1 | Level: received byte waiting |
| tx_space | input | 1 | Level: transmit register empty |
| rx_shift_full | input | 1 | Level: receive shifter full (status bit 11) |
| bus_busy | input | 1 | Level: bus busy (status bit 12) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| irq_code | output | 3 | Current interrupt vector |
| irq_line | output | 1 | Interrupt request level |

## Verification
An event pulse presented before an edge shows up on `irq_code`, `irq_line` and the status read in the cycle after that edge. The receive and transmit levels, and the read data for the address presented, change in the same cycle with no register in between. Clears from status writes and from vector reads take effect one edge after the access. The bench drives every input just after a falling edge, samples one time unit later (well before the next rising edge), and then advances its reference model by exactly one edge. Each comparison therefore pairs the current inputs with the state built by all earlier edges.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
    localparam int NUM_EV = 7;

    // event indices: status bit position == enable bit position == code - 1
    localparam int EV_ARB  = 0;
    localparam int EV_NACK = 1;
    localparam int EV_ACC  = 2;
    localparam int EV_RX   = 3;
    localparam int EV_TX   = 4;
    localparam int EV_STOP = 5;
    localparam int EV_HIT  = 6;

    typedef enum logic [1:0] {
        RA_STATUS = 2'd0,
        RA_ENABLE = 2'd1,
        RA_VECTOR = 2'd2,
        RA_SPARE  = 2'd3
    } reg_addr_e;

    // flags held in flops (others are live levels)
    localparam logic [NUM_EV-1:0] STICKY_SET = 7'b1100111;
    // flags that software may clear by writing ones
    localparam logic [NUM_EV-1:0] W1C_SET    = 7'b0100100;
endpackage

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags #(
    parameter int NUM_EV = 7,
    parameter logic [NUM_EV-1:0] STICKY = '1,
    parameter logic [NUM_EV-1:0] W1C    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_in,
    input  logic [NUM_EV-1:0] w1c_req,
    input  logic [NUM_EV-1:0] rd_clr,
    output logic [NUM_EV-1:0] flag_view
);
    logic [NUM_EV-1:0] clr_any;
    assign clr_any = (w1c_req & W1C) | rd_clr;

    for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
        if (STICKY[i]) begin : g_sticky
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         q <= 1'b0;
                else if (ev_in[i])  q <= 1'b1;   // set beats clear
                else if (clr_any[i]) q <= 1'b0;
            end
            assign flag_view[i] = q;
        end else begin : g_level
            assign flag_view[i] = ev_in[i];
        end
    end
endmodule

// File: rtl/i2c_irq_prio.sv
module i2c_irq_prio #(
    parameter int NUM_EV = 7,
    localparam int CODE_W = $clog2(NUM_EV + 1)
) (
    input  logic [NUM_EV-1:0] pend,
    output logic [CODE_W-1:0] code,
    output logic [NUM_EV-1:0] grant
);
    always_comb begin
        code  = '0;
        grant = '0;
        // walk downward so the lowest index is the last, winning, assignment
        for (int i = NUM_EV - 1; i >= 0; i--) begin
            if (pend[i]) begin
                code     = CODE_W'(i + 1);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_irq_regif.sv
module i2c_irq_regif
    import i2c_irq_pkg::*;
#(
    parameter int NUM_EV  = 7,
    parameter int DATA_W  = 16,
    parameter int RSF_BIT = 11,
    parameter int BB_BIT  = 12,
    localparam int CODE_W = $clog2(NUM_EV + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NUM_EV-1:0] flag_view,
    input  logic              rsf,
    input  logic              busy,
    input  logic [CODE_W-1:0] code,
    input  logic [NUM_EV-1:0] grant,
    output logic [NUM_EV-1:0] mask_q,
    output logic [NUM_EV-1:0] w1c_req,
    output logic [NUM_EV-1:0] rd_clr,
    output logic [DATA_W-1:0] bus_rdata
);
    reg_addr_e addr;
    assign addr = reg_addr_e'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= '0;
        else if (bus_wr && addr == RA_ENABLE)
            mask_q <= bus_wdata[NUM_EV-1:0];
    end

    assign w1c_req = (bus_wr && addr == RA_STATUS) ? bus_wdata[NUM_EV-1:0] : '0;
    assign rd_clr  = (bus_rd && addr == RA_VECTOR) ? grant : '0;

    always_comb begin
        bus_rdata = '0;
        unique case (addr)
            RA_STATUS: begin
                bus_rdata[NUM_EV-1:0] = flag_view;
                bus_rdata[RSF_BIT]    = rsf;
                bus_rdata[BB_BIT]     = busy;
            end
            RA_ENABLE: bus_rdata[NUM_EV-1:0] = mask_q;
            RA_VECTOR: bus_rdata[CODE_W-1:0] = code;
            RA_SPARE:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_irq_vec.sv
module i2c_irq_vec
    import i2c_irq_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int RSF_BIT = 11,
    parameter int BB_BIT  = 12,
    localparam int CODE_W = $clog2(NUM_EV + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_arb_lost,
    input  logic              ev_nack,
    input  logic              ev_acc_rdy,
    input  logic              ev_stop_det,
    input  logic              ev_slave_hit,
    input  logic              rx_avail,
    input  logic              tx_space,
    input  logic              rx_shift_full,
    input  logic              bus_busy,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CODE_W-1:0] irq_code,
    output logic              irq_line
);
    logic [NUM_EV-1:0] ev_vec, flag_view, mask_q, w1c_req, rd_clr, grant;
    logic [CODE_W-1:0] code;

    always_comb begin
        ev_vec          = '0;
        ev_vec[EV_ARB]  = ev_arb_lost;
        ev_vec[EV_NACK] = ev_nack;
        ev_vec[EV_ACC]  = ev_acc_rdy;
        ev_vec[EV_RX]   = rx_avail;
        ev_vec[EV_TX]   = tx_space;
        ev_vec[EV_STOP] = ev_stop_det;
        ev_vec[EV_HIT]  = ev_slave_hit;
    end

    i2c_irq_flags #(.NUM_EV(NUM_EV), .STICKY(STICKY_SET), .W1C(W1C_SET)) u_flags (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_vec), .w1c_req(w1c_req),
        .rd_clr(rd_clr), .flag_view(flag_view)
    );

    i2c_irq_prio #(.NUM_EV(NUM_EV)) u_prio (
        .pend(flag_view & mask_q), .code(code), .grant(grant)
    );

    i2c_irq_regif #(.NUM_EV(NUM_EV), .DATA_W(DATA_W), .RSF_BIT(RSF_BIT), .BB_BIT(BB_BIT)) u_regif (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flag_view(flag_view),
        .rsf(rx_shift_full), .busy(bus_busy), .code(code), .grant(grant),
        .mask_q(mask_q), .w1c_req(w1c_req), .rd_clr(rd_clr), .bus_rdata(bus_rdata)
    );

    assign irq_code = code;
    assign irq_line = |code;
endmodule

// File: rtl/i2c_irq_vec_chk.sv
module i2c_irq_vec_chk #(
    parameter int NUM_EV = 7,
    parameter int DATA_W = 16,
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_arb_lost,
    input logic              ev_acc_rdy,
    input logic              ev_stop_det,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CODE_W-1:0] irq_code,
    input logic [NUM_EV-1:0] flag_view,
    input logic [NUM_EV-1:0] mask_q
);
    a_r2_arb_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arb_lost |=> flag_view[0]);

    a_r3_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> mask_q == $past(bus_wdata[NUM_EV-1:0]));

    a_r5_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_view & mask_q) == '0) |-> irq_code == '0);

    a_r7_w1c_access: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && bus_wdata[2] && !ev_acc_rdy) |=> !flag_view[2]);

    a_r8_read_acks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd2 && irq_code == CODE_W'(1) && !ev_arb_lost) |=> !flag_view[0]);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop_det && bus_wr && bus_addr == 2'd0 && bus_wdata[5]) |=> flag_view[5]);
endmodule

bind i2c_irq_vec i2c_irq_vec_chk #(.NUM_EV(7), .DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_arb_lost(ev_arb_lost), .ev_acc_rdy(ev_acc_rdy),
    .ev_stop_det(ev_stop_det), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq_code(irq_code), .flag_view(flag_view), .mask_q(mask_q)
);

// File: tb/i2c_irq_vec_tb.sv
module i2c_irq_vec_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_arb_lost = 0, ev_nack = 0, ev_acc_rdy = 0, ev_stop_det = 0, ev_slave_hit = 0;
    logic rx_avail = 0, tx_space = 0, rx_shift_full = 0, bus_busy = 0;
    logic bus_wr = 0, bus_rd = 0;
    logic [1:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic [2:0]  irq_code;
    logic        irq_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [6:0]  m_flag = '0;   // sticky flags of the reference model
    logic [6:0]  m_mask = '0;
    logic [2:0]  seen_code;
    logic [15:0] seen_rdata;

    localparam logic [6:0] STICKY = 7'b1100111;
    localparam logic [6:0] W1CB   = 7'b0100100;

    always #5 clk = ~clk;

    i2c_irq_vec u_dut (
        .clk(clk), .rst_n(rst_n), .ev_arb_lost(ev_arb_lost), .ev_nack(ev_nack),
        .ev_acc_rdy(ev_acc_rdy), .ev_stop_det(ev_stop_det), .ev_slave_hit(ev_slave_hit),
        .rx_avail(rx_avail), .tx_space(tx_space), .rx_shift_full(rx_shift_full),
        .bus_busy(bus_busy), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_code(irq_code), .irq_line(irq_line)
    );

    function automatic logic [6:0] view_of(logic [6:0] f, logic rx, logic tx);
        logic [6:0] v;
        v = f & STICKY;
        v[3] = rx;
        v[4] = tx;
        return v;
    endfunction

    function automatic logic [2:0] exp_code(logic [6:0] v, logic [6:0] m);
        logic [6:0] p;
        p = v & m;
        for (int i = 0; i < 7; i++) if (p[i]) return 3'(i + 1);
        return 3'd0;
    endfunction

    function automatic logic [15:0] exp_rdata(logic [1:0] a, logic [6:0] v, logic [6:0] m,
                                              logic rsf, logic bb);
        logic [15:0] r;
        r = '0;
        case (a)
            2'd0: begin r[6:0] = v; r[11] = rsf; r[12] = bb; end
            2'd1: r[6:0] = m;
            2'd2: r[2:0] = exp_code(v, m);
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // p: event pulses by status bit (bits 3,4 unused); op 0 idle, 1 write, 2 read
    task automatic step(input string tag, input logic [6:0] p, input logic rx, input logic tx,
                        input logic rsf, input logic bb, input int op,
                        input logic [1:0] a, input logic [15:0] wd);
        logic [6:0] v;
        logic [2:0] c;
        logic clr;
        ev_arb_lost = p[0]; ev_nack = p[1]; ev_acc_rdy = p[2];
        ev_stop_det = p[5]; ev_slave_hit = p[6];
        rx_avail = rx; tx_space = tx; rx_shift_full = rsf; bus_busy = bb;
        bus_wr = (op == 1); bus_rd = (op == 2); bus_addr = a; bus_wdata = wd;
        #1;
        v = view_of(m_flag, rx, tx);
        c = exp_code(v, m_mask);
        seen_code = irq_code;
        seen_rdata = bus_rdata;
        chk("R4 vector", {13'd0, irq_code}, {13'd0, c});
        chk("R6 line", {15'd0, irq_line}, {15'd0, (c != 0)});
        if (op == 2) chk(tag, bus_rdata, exp_rdata(a, v, m_mask, rsf, bb));
        for (int i = 0; i < 7; i++) begin
            if (STICKY[i]) begin
                clr = (op == 1 && a == 2'd0 && wd[i] && W1CB[i]) ||
                      (op == 2 && a == 2'd2 && c == 3'(i + 1));
                m_flag[i] = p[i] | (m_flag[i] & ~clr);
            end
        end
        if (op == 1 && a == 2'd1) m_mask = wd[6:0];
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(tag, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 2'd0, 16'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        step("R1 status", 7'd0, 0, 0, 0, 0, 2, 2'd0, 16'd0);
        chk("R1 code", {13'd0, seen_code}, 16'd0);
        chk("R1 status", seen_rdata, 16'd0);
        step("R1 enable", 7'd0, 0, 0, 0, 0, 2, 2'd1, 16'd0);
        chk("R1 enable", seen_rdata, 16'd0);

        // R3: enable all
        step("R3", 7'd0, 0, 0, 0, 0, 1, 2'd1, 16'hFFFF);
        step("R3 enable", 7'd0, 0, 0, 0, 0, 2, 2'd1, 16'd0);
        chk("R3 enable", seen_rdata, 16'h007F);

        // R4/R8: two sticky events, lowest code first, acked by reads
        step("R2", 7'b1000001, 0, 0, 0, 0, 0, 2'd0, 16'd0);
        step("R8 read", 7'd0, 0, 0, 0, 0, 2, 2'd2, 16'd0);
        chk("R4 priority", {13'd0, seen_code}, 16'd1);
        step("R8 read", 7'd0, 0, 0, 0, 0, 2, 2'd2, 16'd0);
        chk("R8 acked", {13'd0, seen_code}, 16'd7);
        idle("R8");
        chk("R8 empty", {13'd0, seen_code}, 16'd0);

        // R8: level sources survive a vector read
        step("R8 level", 7'd0, 1, 1, 0, 0, 2, 2'd2, 16'd0);
        chk("R4 rx code", {13'd0, seen_code}, 16'd4);
        step("R8 level", 7'd0, 1, 1, 0, 0, 0, 2'd0, 16'd0);
        chk("R8 level kept", {13'd0, seen_code}, 16'd4);
        step("R4", 7'd0, 0, 1, 0, 0, 0, 2'd0, 16'd0);
        chk("R4 tx code", {13'd0, seen_code}, 16'd5);

        // R5: disabled event still latches
        step("R5", 7'd0, 0, 0, 0, 0, 1, 2'd1, 16'd0);
        step("R5", 7'b0000010, 0, 0, 0, 0, 0, 2'd0, 16'd0);
        step("R5 status", 7'd0, 0, 0, 0, 0, 2, 2'd0, 16'd0);
        chk("R5 code", {13'd0, seen_code}, 16'd0);
        chk("R5 nack flag", {15'd0, seen_rdata[1]}, 16'd1);

        // R7: write ones clears only access-ready and stop
        step("R7", 7'd0, 0, 0, 0, 0, 1, 2'd1, 16'h007F);
        step("R7", 7'b0100101, 0, 0, 0, 0, 0, 2'd0, 16'd0);
        step("R7", 7'd0, 0, 0, 0, 0, 1, 2'd0, 16'hFFFF);
        step("R7 status", 7'd0, 0, 0, 0, 0, 2, 2'd0, 16'd0);
        chk("R7 after w1c", {9'd0, seen_rdata[6:0]}, 16'h0003);

        // R9: set wins over write-one-to-clear and over read ack
        step("R9", 7'b0100000, 0, 0, 0, 0, 1, 2'd0, 16'h0020);
        step("R9 status", 7'd0, 0, 0, 0, 0, 2, 2'd0, 16'd0);
        chk("R9 stop kept", {15'd0, seen_rdata[5]}, 16'd1);
        step("R9", 7'b0000001, 0, 0, 0, 0, 2, 2'd2, 16'd0);
        chk("R9 code", {13'd0, seen_code}, 16'd1);
        idle("R9");
        chk("R9 arb kept", {13'd0, seen_code}, 16'd1);

        // R10: writes to vector/spare ignored, spare reads zero
        step("R10", 7'd0, 0, 0, 0, 0, 1, 2'd2, 16'hFFFF);
        step("R10", 7'd0, 0, 0, 0, 0, 1, 2'd3, 16'hFFFF);
        step("R10 spare", 7'd0, 0, 0, 0, 0, 2, 2'd3, 16'd0);
        chk("R10 code", {13'd0, seen_code}, 16'd1);
        chk("R10 spare", seen_rdata, 16'd0);

        // R2: mirrored level bits
        step("R2 status", 7'd0, 0, 0, 1, 1, 2, 2'd0, 16'd0);
        chk("R2 mirrors", {14'd0, seen_rdata[12:11]}, 16'd3);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [6:0] p;
            int op;
            string tg;
            p = '0;
            for (int i = 0; i < 7; i++) p[i] = ($urandom_range(0, 7) == 0);
            op = $urandom_range(0, 2);
            tg = "R2 rand read";
            step(tg, p, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), op,
                 2'($urandom_range(0, 3)), 16'($urandom()));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule